// File: doc/BRIEF.md
# Low-voltage inhibit reset controller

This block holds the digital side of a supply supervisor. Two analog comparators feed it. One reports that the supply has dropped to or below the falling trip level. The other reports that the supply has climbed above the rising trip level, which sits higher. The block passes both through two-flop synchronizers. It then gates the low-supply detection with three configuration bits (power-down, reset-disable and stop-mode enable) and with the device's stop-mode indication.

The block can run in two modes. In polled mode it only reports the detection through a read-only 8-bit status register. In forced-reset mode it also raises a registered reset request and pulls an active-low reset pin. Once that reset has begun, it holds until the rising comparator reports recovery. This gives hysteresis between the two trip levels. A sticky cause flag records that a low-voltage reset took place, for use by the outer reset sequencer. Only the power-on reset clears it.

Top module: `lvi_supervisor`

## Requirements
- R1: After `por_n` has been low, the status read is 0x00, `lvi_rst_req` is 0, `lvi_rst_pin_n` is 1 and `lvi_cause` is 0.
- R2: The detection flag sits at bit 7 of `reg_rdata` while `reg_sel` is 1. It is 1 when the module is active and the synchronized `below_fall_raw` is 1. A change on `below_fall_raw` therefore appears on bit 7 after two rising clock edges.
- R3: While `cfg_pwrdn` is 1, the flag reads 0. The reset request also falls to 0 at the next edge and stays there.
- R4: In polled mode (`cfg_pwrdn`=0, `cfg_rst_dis`=1), the flag follows the detector and no reset request is started.
- R5: In forced-reset mode (`cfg_pwrdn`=0, `cfg_rst_dis`=0), an active detection sets `lvi_rst_req` on the edge after the synchronized detection. That is three edges after `below_fall_raw` rises.
- R6: An asserted reset request stays 1 after `below_fall_raw` returns to 0. It clears only on the edge after the synchronized `above_rise_raw` is 1, which is three edges after that input rises.
- R7: `lvi_rst_pin_n` is low exactly while `lvi_rst_req` is high.
- R8: Bits 6..0 of `reg_rdata` always read 0, and `reg_rdata` is 0x00 while `reg_sel` is 0. Writes (`reg_wr` with any `reg_wdata`) change nothing.
- R9: Consider stop mode (`stop_mode`=1) with `cfg_stop_en`=0. The detector counts as inactive: the flag reads 0 and no new reset starts. With `cfg_stop_en`=1, detection works in stop mode as it does outside it.
- R10: `lvi_cause` becomes 1 on the same edge that a low-voltage reset request starts. It stays 1 until `por_n` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Active-low power-on reset, asynchronous |
| below_fall_raw | input | 1 | Comparator: supply at or below falling trip level |
| above_rise_raw | input | 1 | Comparator: supply above rising trip level |
| cfg_pwrdn | input | 1 | 1 powers the module down |
| cfg_rst_dis | input | 1 | 1 disables low-voltage resets (polled mode) |
| cfg_stop_en | input | 1 | 1 keeps the detector active in stop mode |
| stop_mode | input | 1 | Device is in stop mode |
| reg_sel | input | 1 | Status register selected |
| reg_wr | input | 1 | Write strobe (ignored) |
| reg_wdata | input | 8 | Write data (ignored) |
| reg_rdata | output | 8 | Status read data |
| lvi_rst_req | output | 1 | Registered low-voltage reset request |
| lvi_rst_pin_n | output | 1 | Active-low reset pin drive |
| lvi_cause | output | 1 | Sticky low-voltage reset cause |

## Verification
The assertions assume that the two comparator inputs are never high together. A supply cannot sit both at or below the lower trip level and above the higher one. They also assume that the configuration and stop inputs change only between clock edges. The stimulus follows both assumptions. It lowers one comparator input before it raises the other, and it drives every input just after the falling clock edge. A behavioural model in the bench holds the comparator samples in short queues and predicts the status byte, the request, the pin and the cause on every cycle.

// File: rtl/lvi_supervisor.sv
module lvi_supervisor #(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              below_fall_raw,
  input  logic              above_rise_raw,
  input  logic              cfg_pwrdn,
  input  logic              cfg_rst_dis,
  input  logic              cfg_stop_en,
  input  logic              stop_mode,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              lvi_rst_req,
  output logic              lvi_rst_pin_n,
  output logic              lvi_cause
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] below_sync, above_sync;
  logic below_s, above_s;
  logic active, detect, rst_q, rst_d;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      below_sync <= '0;
      above_sync <= '0;
    end else begin
      below_sync <= {below_sync[LAST-1:0], below_fall_raw};
      above_sync <= {above_sync[LAST-1:0], above_rise_raw};
    end
  end

  assign below_s = below_sync[LAST];
  assign above_s = above_sync[LAST];

  assign active = !cfg_pwrdn && !(stop_mode && !cfg_stop_en);
  assign detect = active && below_s;

  always_comb begin
    if (cfg_pwrdn)  rst_d = 1'b0;
    else if (rst_q) rst_d = !above_s;
    else            rst_d = detect && !cfg_rst_dis;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rst_q     <= 1'b0;
      lvi_cause <= 1'b0;
    end else begin
      rst_q <= rst_d;
      if (rst_d && !rst_q) lvi_cause <= 1'b1;
    end
  end

  assign lvi_rst_req   = rst_q;
  assign lvi_rst_pin_n = !rst_q;
  assign reg_rdata     = reg_sel ? {detect, {(DATA_W-1){1'b0}}} : '0;

  assert_pwrdn_quiet_R3: assert property (@(posedge clk) disable iff (!por_n)
    cfg_pwrdn |=> !lvi_rst_req);

  assert_polled_no_reset_R4: assert property (@(posedge clk) disable iff (!por_n)
    (cfg_rst_dis && !lvi_rst_req) |=> !lvi_rst_req);

  assert_hold_until_rise_R6: assert property (@(posedge clk) disable iff (!por_n)
    (lvi_rst_req && !above_s && !cfg_pwrdn) |=> lvi_rst_req);

  assert_pin_tracks_R7: assert property (@(posedge clk) disable iff (!por_n)
    $fell(lvi_rst_pin_n) |-> $rose(lvi_rst_req));

  assert_low_bits_zero_R8: assert property (@(posedge clk) disable iff (!por_n)
    (reg_sel && reg_wr && reg_wdata != '0) |-> reg_rdata[DATA_W-2:0] == '0);

  assert_stop_gates_R9: assert property (@(posedge clk) disable iff (!por_n)
    (stop_mode && !cfg_stop_en && !lvi_rst_req) |=> !lvi_rst_req);

  assert_cause_on_reset_R10: assert property (@(posedge clk) disable iff (!por_n)
    $rose(lvi_rst_req) |-> lvi_cause);

endmodule

// File: tb/lvi_supervisor_tb.sv
module lvi_supervisor_tb;
  logic clk = 0, por_n = 0;
  logic below = 0, above = 0, pwrdn = 0, rdis = 0, sten = 0, stp = 0;
  logic sel = 1, wr = 0;
  logic [7:0] wdata = 0, rdata;
  logic rreq, rpin, cause;
  int tests = 0, fails = 0;
  string tag = "R1";

  bit bq[$] = '{0, 0};
  bit aq[$] = '{0, 0};
  bit m_rst = 0, m_cause = 0;

  always #5 clk = ~clk;

  lvi_supervisor u_dut (
    .clk(clk), .por_n(por_n), .below_fall_raw(below), .above_rise_raw(above),
    .cfg_pwrdn(pwrdn), .cfg_rst_dis(rdis), .cfg_stop_en(sten), .stop_mode(stp),
    .reg_sel(sel), .reg_wr(wr), .reg_wdata(wdata), .reg_rdata(rdata),
    .lvi_rst_req(rreq), .lvi_rst_pin_n(rpin), .lvi_cause(cause));

  function automatic bit m_active();
    return !pwrdn && !(stp && !sten);
  endfunction

  always @(posedge clk) begin
    if (!por_n) begin
      bq = '{0, 0}; aq = '{0, 0}; m_rst = 0; m_cause = 0;
    end else begin
      bit det;
      bit nxt;
      det = m_active() && bq[0];
      if (pwrdn) nxt = 0;
      else if (m_rst) nxt = !aq[0];
      else nxt = det && !rdis;
      if (nxt && !m_rst) m_cause = 1;
      m_rst = nxt;
      void'(bq.pop_front()); bq.push_back(below);
      void'(aq.pop_front()); aq.push_back(above);
    end
  end

  task automatic chk(string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #4;
    if (por_n) begin
      chk("rdata", rdata, (sel && m_active() && bq[0]) ? 8'h80 : 8'h00);
      chk("rst_req", rreq, m_rst);
      chk("rst_pin_n R7", rpin, !m_rst);
      chk("cause R10", cause, m_cause);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    cyc(3);
    tag = "R1";
    chk("rdata", rdata, 0); chk("rst_req", rreq, 0);
    chk("pin", rpin, 1); chk("cause", cause, 0);
    por_n = 1; cyc(3);

    tag = "R4"; rdis = 1; below = 1; cyc(2);
    tag = "R2"; chk("flag latency", rdata, 8'h80);
    tag = "R4"; cyc(6); chk("no reset", rreq, 0);
    below = 0; cyc(4);

    tag = "R5"; rdis = 0; below = 1; cyc(2);
    chk("not yet", rreq, 0); cyc(1); chk("asserted", rreq, 1);
    tag = "R6"; below = 0; cyc(8); chk("held", rreq, 1);
    above = 1; cyc(2); chk("still held", rreq, 1); cyc(1);
    chk("released", rreq, 0);
    above = 0; cyc(3);

    tag = "R3"; pwrdn = 1; below = 1; cyc(6);
    chk("flag off", rdata, 0); chk("no reset", rreq, 0);
    pwrdn = 0; cyc(4); chk("reset after enable", rreq, 1);
    pwrdn = 1; cyc(1); chk("pwrdn clears", rreq, 0);
    below = 0; pwrdn = 0; cyc(4);

    tag = "R10"; chk("sticky", cause, 1);
    por_n = 0; cyc(2); chk("cleared by por", cause, 0); por_n = 1; cyc(3);

    tag = "R9"; stp = 1; sten = 0; below = 1; cyc(6);
    chk("flag off", rdata, 0); chk("no reset", rreq, 0);
    sten = 1; cyc(1); chk("flag on", rdata, 8'h80); cyc(1);
    chk("reset in stop", rreq, 1);
    below = 0; above = 1; cyc(5); above = 0; stp = 0; sten = 0; cyc(3);

    tag = "R8"; wr = 1; wdata = 8'hFF; cyc(1); chk("write ignored", rdata, 0);
    wr = 0; rdis = 1; below = 1; cyc(3); sel = 0; cyc(1);
    chk("deselected", rdata, 0); sel = 1; cyc(1); chk("upper only", rdata, 8'h80);
    wr = 1; wdata = 8'h00; cyc(1); chk("write ignored set", rdata, 8'h80);
    wr = 0; below = 0; cyc(4);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #200000;
    tests++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule